// File: doc/BRIEF.md
# Link Packet Framer with Sequence Numbering

This block sits in the transmit path of a link layer. It turns each transaction packet into a complete link frame on a 32-bit word stream. When a start strobe arrives while the block is idle, it takes the current value of its 12-bit sequence counter for the new frame and advances the counter. It then emits the frame in three parts: one word carrying the sequence number, every payload word passed through from upstream, and a 32-bit link CRC. The CRC is built one word per clock over the sequence word and the payload.

Payload words arrive on a valid/ready input. The strobe marks the start of a packet and a last flag marks its end, so payload lengths from one word up to 1024 words (4096 bytes) need no extra control. The output carries its own valid/ready pair and three phase flags, one each for the sequence word, payload words and the CRC word. Downstream back-pressure stalls the frame without losing or changing any word.

Top module: `link_frame_builder`

## Requirements
- R1: After reset, `out_valid_o` and `in_ready_o` are low, and the first frame carries sequence number 0.
- R2: Each frame is exactly one word with `out_sof_o`, then the payload words with `out_dat_o`, then one word with `out_eof_o`. While `out_valid_o` is high, exactly one of the three flags is set. After the CRC word is accepted, `out_valid_o` stays low until the next start.
- R3: The sequence word holds the sequence number in bits 11:0, with bits 31:12 zero.
- R4: Each accepted start gives a frame whose sequence number is one more than the previous frame's. The number wraps from 4095 to 0.
- R5: The CRC word is the bitwise inverse of a CRC-32 with polynomial 0x04C11DB7 and an all-ones seed. It is shifted MSB first over the sequence word and then each payload word in order.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the sequence word and the CRC word hold their value and flags, and no payload word is taken from upstream.
- R7: A start strobe that arrives while a frame is in progress is ignored. It produces no extra frame, and the sequence counter does not advance.
- R8: `in_ready_o` is high only in the payload phase, where it follows `out_ready_i`. Each accepted payload word appears unchanged on `out_data_o` in the same cycle.
- R9: A payload of a single word (with the last flag set on its first word) and a payload of 1024 words both form correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a new frame, taken only when idle |
| in_valid_i | input | 1 | Payload word valid |
| in_data_i | input | 32 | Payload word |
| in_last_i | input | 1 | Marks the final payload word |
| in_ready_o | output | 1 | Payload word accepted when high with valid |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream can take a word |
| out_data_o | output | 32 | Frame word |
| out_sof_o | output | 1 | Word is the sequence word |
| out_dat_o | output | 1 | Word is a payload word |
| out_eof_o | output | 1 | Word is the CRC word |

## Verification
The bench uses the default parameters: a 12-bit sequence and 32-bit words. With these widths, a run of a little over 4096 one-word frames drives the counter through its wrap from 4095 to 0. A 1024-word frame reaches the largest payload. Random downstream stalls and upstream gaps are applied on top of this, and a start strobe is injected into a running frame to confirm it is ignored.

// File: rtl/link_frame_builder.sv
module link_frame_builder #(
  parameter int SEQ_W = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] POLY = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_sof_o,
  output logic          out_dat_o,
  output logic          out_eof_o
);
  localparam int PAD_W = DW - SEQ_W;

  typedef enum logic [1:0] {PH_IDLE, PH_SEQ, PH_PAY, PH_CRC} phase_t;

  phase_t ph_q;
  logic [SEQ_W-1:0] next_seq_q, frame_seq_q;
  logic [DW-1:0] crc_q;

  function automatic logic [DW-1:0] crc_fold(input logic [DW-1:0] c, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = c;
    for (int b = DW - 1; b >= 0; b--)
      r = (r[DW-1] ^ d[b]) ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  wire out_fire = out_valid_o & out_ready_i;

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_sof_o   = 1'b0;
    out_dat_o   = 1'b0;
    out_eof_o   = 1'b0;
    in_ready_o  = 1'b0;
    case (ph_q)
      PH_SEQ: begin
        out_valid_o = 1'b1;
        out_data_o  = {{PAD_W{1'b0}}, frame_seq_q};
        out_sof_o   = 1'b1;
      end
      PH_PAY: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_dat_o   = 1'b1;
        in_ready_o  = out_ready_i;
      end
      PH_CRC: begin
        out_valid_o = 1'b1;
        out_data_o  = ~crc_q;
        out_eof_o   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      next_seq_q  <= '0;
      frame_seq_q <= '0;
      crc_q       <= '1;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          frame_seq_q <= next_seq_q;
          next_seq_q  <= next_seq_q + 1'b1;
          crc_q       <= '1;
          ph_q        <= PH_SEQ;
        end
        PH_SEQ: if (out_ready_i) begin
          crc_q <= crc_fold(crc_q, out_data_o);
          ph_q  <= PH_PAY;
        end
        PH_PAY: if (in_valid_i && out_ready_i) begin
          crc_q <= crc_fold(crc_q, in_data_i);
          if (in_last_i) ph_q <= PH_CRC;
        end
        PH_CRC: if (out_ready_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // checker state for sequence stepping
  logic seen_q;
  logic [SEQ_W-1:0] last_seq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_seq_q <= '0;
    end else if (out_fire && out_sof_o) begin
      seen_q     <= 1'b1;
      last_seq_q <= out_data_o[SEQ_W-1:0];
    end
  end

  assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $onehot({out_sof_o, out_dat_o, out_eof_o}));

  assert_idle_after_crc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eof_o) |=> !out_valid_o);

  assert_seq_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sof_o) |-> (out_data_o[DW-1:SEQ_W] == '0));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_sof_o && seen_q) |-> (out_data_o[SEQ_W-1:0] == SEQ_W'(last_seq_q + 1'b1)));

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !out_dat_o) |=>
      (out_valid_o && $stable(out_data_o) && $stable({out_sof_o, out_eof_o})));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |-> (out_valid_o && out_ready_i && out_dat_o && out_data_o == in_data_i));

endmodule

// File: tb/link_frame_builder_tb_top.sv
`timescale 1ns/1ps
module link_frame_builder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0, out_ready_i = 1'b1;
  logic [31:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_sof_o, out_dat_o, out_eof_o;
  logic [31:0] out_data_o;

  always #10 clk = ~clk;

  link_frame_builder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_dat_o(out_dat_o), .out_eof_o(out_eof_o));

  int checks = 0, errors = 0, cyc = 0, stall_pct = 0;
  bit gaps = 0;
  logic [11:0] model_seq = '0;
  logic [34:0] exp_q[$];

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    for (int b = 31; b >= 0; b--)
      c = (c[31] ^ w[b]) ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    out_ready_i = (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready_i) begin
      logic [34:0] act, exp;
      string req;
      act = {out_sof_o, out_dat_o, out_eof_o, out_data_o};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected word", act, '0);
      end else begin
        exp = exp_q.pop_front();
        req = exp[34] ? "R1 R3 R4" : (exp[33] ? "R2 R8 R9" : "R5 R2");
        if (stall_pct != 0) req = {req, " R6"};
        chk(act === exp, req, act, exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_frame(input int n, input bit mid_start);
    logic [31:0] pay[$];
    logic [31:0] c, sw;
    bit acc;
    c = '1;
    sw = {20'h0, model_seq};
    exp_q.push_back({3'b100, sw});
    c = ref_crc(c, sw);
    for (int i = 0; i < n; i++) begin
      pay.push_back($urandom);
      exp_q.push_back({3'b010, pay[i]});
      c = ref_crc(c, pay[i]);
    end
    exp_q.push_back({3'b001, ~c});
    model_seq = model_seq + 1'b1;
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(posedge clk); #1;
      end
      in_valid_i = 1'b1;
      in_data_i  = pay[i];
      in_last_i  = (i == n - 1);
      if (mid_start && i == 0) start_i = 1'b1;  // R7 stray strobe
      do begin
        @(negedge clk); acc = in_ready_o;
        @(posedge clk); #1;
        start_i = 1'b0;
      end while (!acc);
      in_valid_i = 1'b0;
      in_last_i  = 1'b0;
    end
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 out_valid in reset", {34'h0, out_valid_o}, '0);
    chk(in_ready_o == 1'b0, "R1 in_ready in reset", {34'h0, in_ready_o}, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 idle after reset", {34'h0, out_valid_o}, '0);
    chk(in_ready_o == 1'b0, "R8 no ready when idle", {34'h0, in_ready_o}, '0);
    send_frame(1, 0);           // R9 single word, R1 seq 0
    send_frame(2, 0);
    send_frame(5, 0);
    send_frame(32, 0);
    stall_pct = 40; gaps = 1;   // R6 stalls with upstream gaps
    send_frame(7, 0);
    send_frame(20, 0);
    send_frame(3, 1);           // R7
    repeat (4) @(negedge clk);
    chk(out_valid_o == 1'b0, "R7 no extra frame", {34'h0, out_valid_o}, '0);
    send_frame(4, 0);           // R7 counter did not advance
    stall_pct = 30;
    send_frame(1024, 0);        // R9 longest payload
    stall_pct = 0; gaps = 0;
    for (int k = 0; k < 4100; k++) send_frame(1, 0);  // R4 wrap
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all words seen", 35'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule